// File: doc/BRIEF.md
# I2C Control Flag Register

This block keeps the three control flags of an I2C controller that software and the serial engine both act on. The flags are a stop request, an interrupt flag that also suspends the bus, and an acknowledge-enable flag. Software changes them only through two write strobes. One strobe sets the bits written as 1. The other clears the bits written as 1. The serial byte/bit engine reports what happens on the bus: state changes with their state code, an address match, a general-call match, a received data byte with the current receive mode, and the end of a generated STOP.

From the flags and these events the block drives four things. It holds SCL low while the interrupt flag is pending. It chooses the level driven on SDA in the acknowledge slot. It asks the engine to generate a STOP when in master mode. In slave mode it orders an error recovery: the engine returns to the not-addressed slave receiver state as if a STOP had been received, and no STOP is put on the bus. A read-back vector shows the flags in their register positions.

Top module: `i2c_ctl_flags`

## Requirements
- R1: During and right after reset, all flags read 0, and `scl_hold`, `stop_req`, `slave_recover` and `ack_valid` are 0 while `ack_sda` is 1.
- R2: A cycle with `set_we` high sets each flag whose bit in `set_data` is 1. The bit positions are acknowledge-enable = bit 2, interrupt = bit 3 and stop = bit 4. Bits written as 0 change nothing. The new value shows on `ctl_rdata` after the clock edge.
- R3: A cycle with `clr_we` high clears acknowledge-enable for bit 2 of `clr_data` and the interrupt flag for bit 3. Zero bits have no effect. Bits 0, 1 and 4 to 7 are ignored, so software cannot clear the stop flag.
- R4: If the same flag is set and cleared by software in one cycle, it ends up cleared.
- R5: A state-change strobe whose code is not 0xF8 sets the interrupt flag at the next edge. A state change to 0xF8 never sets it.
- R6: Hardware never clears the interrupt flag. A state-change event in the same cycle as a software clear of that flag leaves it set.
- R7: `scl_hold` is 1 exactly when the interrupt flag is 1 and `scl_high` is 0.
- R8: In master mode a set stop flag drives `stop_req`. The flag stays set until the cycle after `stop_seen`, then clears.
- R9: In slave mode a set stop flag raises `slave_recover` for one cycle with `stop_req` low, and the flag clears at the next edge.
- R10: `ack_valid` is 1 in the same cycle as any of these: an own-address match; a general-call match with `gc_enable` high; or a data byte received with `rx_mode` = 1 (master receive) or 2 (addressed slave receive). Codes 0 and 3 do not qualify. When acknowledge-enable is 1, `ack_sda` is 0 (ACK) in that cycle.
- R11: With acknowledge-enable 0, a qualifying event gives `ack_sda` = 1 (NACK). Whenever `ack_valid` is 0, `ack_sda` is 1.
- R12: Reserved bits 0, 1 and 5 to 7 of `ctl_rdata` always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Write strobe of the set register |
| set_data | input | 8 | Write-one-to-set data |
| clr_we | input | 1 | Write strobe of the clear register |
| clr_data | input | 8 | Write-one-to-clear data |
| ctl_rdata | output | 8 | Flag read-back |
| ev_state_chg | input | 1 | Engine state-change strobe |
| ev_state_code | input | 8 | Engine state code for the new state |
| ev_own_addr | input | 1 | Own slave address received |
| ev_gen_call | input | 1 | General-call address received |
| gc_enable | input | 1 | General-call response enabled |
| ev_data_rx | input | 1 | Data byte received |
| rx_mode | input | 2 | Receive mode: 1 master, 2 addressed slave, 0/3 other |
| is_master | input | 1 | Controller is in master mode |
| scl_high | input | 1 | SCL is in its high phase |
| stop_seen | input | 1 | Engine finished the STOP on the bus |
| scl_hold | output | 1 | Hold SCL low |
| stop_req | output | 1 | Request a STOP condition |
| slave_recover | output | 1 | Force not-addressed slave state |
| ack_valid | output | 1 | Acknowledge slot decision is due |
| ack_sda | output | 1 | SDA level for the acknowledge slot |

## Verification
Some rules are checked by assertions on every cycle:
- reserved bits stay 0;
- SCL is never held while high;
- the interrupt flag falls only after a software clear with no competing event;
- `stop_req` is seen only in master mode;
- a slave-mode stop flag always produces a recovery and then clears;
- the acknowledge level matches acknowledge-enable whenever a decision is due.

Other behaviour only shows in the bench's scenarios:
- how long the stop flag stays set while waiting for `stop_seen`;
- that the 0xF8 code is skipped while other codes are not;
- that zero bits and reserved bits of both write registers do nothing;
- the full table of which event and mode combinations need an acknowledge.

// File: rtl/i2c_cf_pkg.sv
`timescale 1ns/1ps
package i2c_cf_pkg;
  localparam int REG_W   = 8;
  localparam int AA_POS  = 2;
  localparam int SI_POS  = 3;
  localparam int STO_POS = 4;

  typedef enum logic [1:0] {
    RXM_NONE = 2'd0,
    RXM_MST  = 2'd1,
    RXM_SLV  = 2'd2,
    RXM_IDLE = 2'd3
  } rx_mode_e;

  // next value of a software flag: clear beats set
  function automatic logic sw_flag_next(input logic cur, input logic set_b,
                                        input logic clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

  // does the current bus event need an acknowledge-slot decision
  function automatic logic ack_due(input logic own, input logic gc,
                                   input logic gc_en, input logic drx,
                                   input rx_mode_e mode);
    logic rx_ok;
    rx_ok = (mode == RXM_MST) || (mode == RXM_SLV);
    return own | (gc & gc_en) | (drx & rx_ok);
  endfunction
endpackage

// File: rtl/i2c_cf_flags.sv
`timescale 1ns/1ps
module i2c_cf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_aa,
  input  logic set_si,
  input  logic set_sto,
  input  logic clr_aa,
  input  logic clr_si,
  input  logic si_event,
  input  logic sto_hw_clr,
  output logic aa_q,
  output logic si_q,
  output logic sto_q
);
  import i2c_cf_pkg::*;

  logic aa_d, si_d, sto_d;

  always_comb begin
    aa_d  = sw_flag_next(aa_q, set_aa, clr_aa);
    si_d  = si_event | sw_flag_next(si_q, set_si, clr_si);
    sto_d = set_sto | (sto_q & ~sto_hw_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aa_q  <= 1'b0;
      si_q  <= 1'b0;
      sto_q <= 1'b0;
    end else begin
      aa_q  <= aa_d;
      si_q  <= si_d;
      sto_q <= sto_d;
    end
  end
endmodule

// File: rtl/i2c_cf_ack.sv
`timescale 1ns/1ps
module i2c_cf_ack (
  input  logic       aa_q,
  input  logic       own_addr,
  input  logic       gen_call,
  input  logic       gc_enable,
  input  logic       data_rx,
  input  logic [1:0] rx_mode,
  output logic       ack_valid,
  output logic       ack_sda
);
  import i2c_cf_pkg::*;

  always_comb begin
    ack_valid = ack_due(own_addr, gen_call, gc_enable, data_rx, rx_mode_e'(rx_mode));
    ack_sda   = ack_valid ? ~aa_q : 1'b1;
  end
endmodule

// File: rtl/i2c_cf_bus.sv
`timescale 1ns/1ps
module i2c_cf_bus (
  input  logic si_q,
  input  logic sto_q,
  input  logic is_master,
  input  logic scl_high,
  input  logic stop_seen,
  output logic scl_hold,
  output logic stop_req,
  output logic slave_recover,
  output logic sto_hw_clr
);
  always_comb begin
    scl_hold      = si_q & ~scl_high;
    stop_req      = sto_q & is_master;
    slave_recover = sto_q & ~is_master;
    sto_hw_clr    = is_master ? (sto_q & stop_seen) : sto_q;
  end
endmodule

// File: rtl/i2c_ctl_flags.sv
`timescale 1ns/1ps
module i2c_ctl_flags #(
  parameter int          STATE_W   = 8,
  parameter logic [7:0]  IDLE_CODE = 8'hF8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic [7:0]         set_data,
  input  logic               clr_we,
  input  logic [7:0]         clr_data,
  output logic [7:0]         ctl_rdata,
  input  logic               ev_state_chg,
  input  logic [STATE_W-1:0] ev_state_code,
  input  logic               ev_own_addr,
  input  logic               ev_gen_call,
  input  logic               gc_enable,
  input  logic               ev_data_rx,
  input  logic [1:0]         rx_mode,
  input  logic               is_master,
  input  logic               scl_high,
  input  logic               stop_seen,
  output logic               scl_hold,
  output logic               stop_req,
  output logic               slave_recover,
  output logic               ack_valid,
  output logic               ack_sda
);
  import i2c_cf_pkg::*;

  localparam logic [REG_W-1:0] SET_MASK = REG_W'((1 << AA_POS) | (1 << SI_POS) | (1 << STO_POS));
  localparam logic [REG_W-1:0] CLR_MASK = REG_W'((1 << AA_POS) | (1 << SI_POS));
  localparam logic [STATE_W-1:0] IDLE_ST = STATE_W'(IDLE_CODE);

  // named internal events, visible to the bound checker
  logic [REG_W-1:0] set_hit, clr_hit;
  logic si_event, si_sw_clr, sto_hw_clr;
  logic aa_q, si_q, sto_q;
  logic unused_rsvd;

  assign set_hit     = set_we ? (set_data & SET_MASK) : '0;
  assign clr_hit     = clr_we ? (clr_data & CLR_MASK) : '0;
  assign unused_rsvd = ^{set_hit & ~SET_MASK, clr_hit & ~CLR_MASK};
  assign si_event    = ev_state_chg && (ev_state_code != IDLE_ST);
  assign si_sw_clr   = clr_hit[SI_POS];

  i2c_cf_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_aa     (set_hit[AA_POS]),
    .set_si     (set_hit[SI_POS]),
    .set_sto    (set_hit[STO_POS]),
    .clr_aa     (clr_hit[AA_POS]),
    .clr_si     (si_sw_clr),
    .si_event   (si_event),
    .sto_hw_clr (sto_hw_clr),
    .aa_q       (aa_q),
    .si_q       (si_q),
    .sto_q      (sto_q)
  );

  i2c_cf_ack u_ack (
    .aa_q      (aa_q),
    .own_addr  (ev_own_addr),
    .gen_call  (ev_gen_call),
    .gc_enable (gc_enable),
    .data_rx   (ev_data_rx),
    .rx_mode   (rx_mode),
    .ack_valid (ack_valid),
    .ack_sda   (ack_sda)
  );

  i2c_cf_bus u_bus (
    .si_q          (si_q),
    .sto_q         (sto_q),
    .is_master     (is_master),
    .scl_high      (scl_high),
    .stop_seen     (stop_seen),
    .scl_hold      (scl_hold),
    .stop_req      (stop_req),
    .slave_recover (slave_recover),
    .sto_hw_clr    (sto_hw_clr)
  );

  // read-back: flag bits at their positions, reserved bits tied to 0
  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b == AA_POS)       begin : g_aa  assign ctl_rdata[b] = aa_q;  end
    else if (b == SI_POS)  begin : g_si  assign ctl_rdata[b] = si_q;  end
    else if (b == STO_POS) begin : g_sto assign ctl_rdata[b] = sto_q; end
    else                   begin : g_rs  assign ctl_rdata[b] = 1'b0;  end
  end
endmodule

// File: rtl/i2c_ctl_flags_chk.sv
`timescale 1ns/1ps
module i2c_ctl_flags_chk #(
  parameter int         STATE_W   = 8,
  parameter logic [7:0] IDLE_CODE = 8'hF8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               set_we,
  input logic [7:0]         set_data,
  input logic               clr_we,
  input logic [7:0]         clr_data,
  input logic [7:0]         ctl_rdata,
  input logic               ev_state_chg,
  input logic [STATE_W-1:0] ev_state_code,
  input logic               ev_own_addr,
  input logic               ev_gen_call,
  input logic               gc_enable,
  input logic               ev_data_rx,
  input logic               is_master,
  input logic               scl_high,
  input logic               stop_seen,
  input logic               scl_hold,
  input logic               stop_req,
  input logic               slave_recover,
  input logic               ack_valid,
  input logic               ack_sda,
  input logic               si_event
);
  localparam logic [STATE_W-1:0] IDLE_ST = STATE_W'(IDLE_CODE);

  assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[1:0] == 2'b00) && (ctl_rdata[7:5] == 3'b000));

  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && clr_we && set_data[2] && clr_data[2]) |=> !ctl_rdata[2]);

  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    si_event |=> ctl_rdata[3]);

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_state_chg && ev_state_code == IDLE_ST && !ctl_rdata[3] && !(set_we && set_data[3]))
      |=> !ctl_rdata[3]);

  assert_si_sw_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[3]) |-> $past(clr_we && clr_data[3] && !ev_state_chg));

  assert_scl_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_high |-> !scl_hold);

  assert_scl_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[3] && !scl_high) |-> scl_hold);

  assert_stop_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (is_master && ctl_rdata[4]));

  assert_sto_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4] && is_master && !stop_seen) |=> ctl_rdata[4]);

  assert_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[4] && !is_master) |-> (slave_recover && !stop_req));

  assert_recover_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_recover && !(set_we && set_data[4])) |=> !ctl_rdata[4]);

  assert_ack_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_sda == !ctl_rdata[2]));

  assert_gc_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_gen_call && !gc_enable && !ev_own_addr && !ev_data_rx) |-> !ack_valid);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> ack_sda);
endmodule

bind i2c_ctl_flags i2c_ctl_flags_chk #(.STATE_W(STATE_W), .IDLE_CODE(IDLE_CODE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .set_we        (set_we),
  .set_data      (set_data),
  .clr_we        (clr_we),
  .clr_data      (clr_data),
  .ctl_rdata     (ctl_rdata),
  .ev_state_chg  (ev_state_chg),
  .ev_state_code (ev_state_code),
  .ev_own_addr   (ev_own_addr),
  .ev_gen_call   (ev_gen_call),
  .gc_enable     (gc_enable),
  .ev_data_rx    (ev_data_rx),
  .is_master     (is_master),
  .scl_high      (scl_high),
  .stop_seen     (stop_seen),
  .scl_hold      (scl_hold),
  .stop_req      (stop_req),
  .slave_recover (slave_recover),
  .ack_valid     (ack_valid),
  .ack_sda       (ack_sda),
  .si_event      (si_event)
);

// File: tb/i2c_ctl_flags_bench.sv
`timescale 1ns/1ps
module i2c_ctl_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_we = 1'b0, clr_we = 1'b0;
  logic [7:0] set_data = '0, clr_data = '0;
  logic [7:0] ctl_rdata;
  logic       ev_state_chg = 1'b0;
  logic [7:0] ev_state_code = '0;
  logic       ev_own_addr = 1'b0, ev_gen_call = 1'b0, gc_enable = 1'b0, ev_data_rx = 1'b0;
  logic [1:0] rx_mode = '0;
  logic       is_master = 1'b0, scl_high = 1'b0, stop_seen = 1'b0;
  logic       scl_hold, stop_req, slave_recover, ack_valid, ack_sda;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_ctl_flags u_i2c_ctl_flags (.*);

  // {aa, own, gc, gc_en, drx, mode[1:0], exp_valid, exp_sda}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_1_0_0_0_00_1_0,
    9'b0_1_0_0_0_00_1_1,
    9'b1_0_1_1_0_00_1_0,
    9'b1_0_1_0_0_00_0_1,
    9'b0_0_1_1_0_00_1_1,
    9'b1_0_0_0_1_01_1_0,
    9'b1_0_0_0_1_10_1_0,
    9'b0_0_0_0_1_01_1_1,
    9'b0_0_0_0_1_10_1_1,
    9'b1_0_0_0_1_00_0_1,
    9'b1_0_0_0_1_11_0_1,
    9'b1_0_0_0_0_00_0_1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after an edge, let the next edge capture, settle 1ns past it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_set(input logic [7:0] d);
    set_we = 1'b1; set_data = d;
    step();
    set_we = 1'b0; set_data = '0;
    #0.5;
  endtask

  task automatic wr_clr(input logic [7:0] d);
    clr_we = 1'b1; clr_data = d;
    step();
    clr_we = 1'b0; clr_data = '0;
    #0.5;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) step();
    #0.5;
    chk("R1 rdata in reset", ctl_rdata, 8'h00);
    chk("R1 outputs in reset", {3'b0, scl_hold, stop_req, slave_recover, ack_valid, ack_sda}, 8'h01);
    rst_n = 1'b1;
    step();
    #0.5;
    chk("R1 rdata after reset", ctl_rdata, 8'h00);

    // R2: set register
    wr_set(8'h04);
    chk("R2 set AA", ctl_rdata, 8'h04);
    wr_set(8'h00);
    chk("R2 zero write ignored", ctl_rdata, 8'h04);
    wr_set(8'hE3);
    chk("R12 reserved set bits read 0", ctl_rdata, 8'h04);

    // R3: clear register
    wr_clr(8'h00);
    chk("R3 zero clear ignored", ctl_rdata, 8'h04);
    wr_clr(8'h04);
    chk("R3 clear AA", ctl_rdata, 8'h00);

    // R7: SCL hold follows SI and SCL phase
    wr_set(8'h08);
    chk("R2 set SI", ctl_rdata, 8'h08);
    scl_high = 1'b0; #0.5;
    chk("R7 hold while low", {7'b0, scl_hold}, 8'h01);
    scl_high = 1'b1; #0.5;
    chk("R7 no hold while high", {7'b0, scl_hold}, 8'h00);
    scl_high = 1'b0;
    wr_clr(8'h08);
    chk("R3 clear SI", ctl_rdata, 8'h00);
    chk("R7 release after clear", {7'b0, scl_hold}, 8'h00);

    // R4: set and clear in one cycle
    set_we = 1'b1; set_data = 8'h0C; clr_we = 1'b1; clr_data = 8'h0C;
    step();
    set_we = 1'b0; set_data = '0; clr_we = 1'b0; clr_data = '0;
    #0.5;
    chk("R4 clear wins", ctl_rdata, 8'h00);

    // R5: state change sets SI, 0xF8 never does
    ev_state_chg = 1'b1; ev_state_code = 8'h08; #0.5;
    chk("R5 SI not yet set", ctl_rdata, 8'h00);
    step();
    ev_state_chg = 1'b0; #0.5;
    chk("R5 state change sets SI", ctl_rdata, 8'h08);
    wr_clr(8'h08);
    ev_state_chg = 1'b1; ev_state_code = 8'hF8;
    step();
    ev_state_chg = 1'b0; #0.5;
    chk("R5 code F8 leaves SI clear", ctl_rdata, 8'h00);

    // R6: SI persists; event beats SIC
    ev_state_chg = 1'b1; ev_state_code = 8'h50;
    step();
    ev_state_chg = 1'b0;
    repeat (4) step();
    #0.5;
    chk("R6 SI held without software", ctl_rdata, 8'h08);
    ev_state_chg = 1'b1; ev_state_code = 8'h58; clr_we = 1'b1; clr_data = 8'h08;
    step();
    ev_state_chg = 1'b0; clr_we = 1'b0; clr_data = '0; #0.5;
    chk("R6 event beats SIC", ctl_rdata, 8'h08);
    wr_clr(8'h08);

    // R8: master STOP
    is_master = 1'b1;
    wr_set(8'h10);
    chk("R8 STO set", ctl_rdata, 8'h10);
    chk("R8 stop_req/recover", {6'b0, stop_req, slave_recover}, 8'h02);
    wr_clr(8'h10);
    chk("R3 STO not software-clearable", ctl_rdata, 8'h10);
    repeat (3) step();
    #0.5;
    chk("R8 STO waits for stop_seen", ctl_rdata, 8'h10);
    stop_seen = 1'b1;
    step();
    stop_seen = 1'b0; #0.5;
    chk("R8 STO cleared after stop", ctl_rdata, 8'h00);
    chk("R8 stop_req dropped", {7'b0, stop_req}, 8'h00);

    // R9: slave recovery
    is_master = 1'b0;
    wr_set(8'h10);
    chk("R9 recover pulse", {6'b0, stop_req, slave_recover}, 8'h01);
    chk("R9 STO visible", ctl_rdata, 8'h10);
    step();
    #0.5;
    chk("R9 STO self-clears", ctl_rdata, 8'h00);
    chk("R9 recover ends", {7'b0, slave_recover}, 8'h00);

    // R10 / R11: acknowledge table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][8]) wr_set(8'h04); else wr_clr(8'h04);
      ev_own_addr = VEC[i][7]; ev_gen_call = VEC[i][6]; gc_enable = VEC[i][5];
      ev_data_rx  = VEC[i][4]; rx_mode = VEC[i][3:2];
      #0.5;
      chk(VEC[i][1] ? "R10 ack decision" : "R11 no decision",
          {6'b0, ack_valid, ack_sda}, {6'b0, VEC[i][1], VEC[i][0]});
      ev_own_addr = 1'b0; ev_gen_call = 1'b0; gc_enable = 1'b0;
      ev_data_rx = 1'b0; rx_mode = '0;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule